// File: doc/BRIEF.md
# Level-2 Trigger Scheduler

The scheduler decides when a level-2 trigger follows the level-1 triggers that a trigger system has accepted. It can take its level-2 decisions from one of three origins. In automatic mode it makes them itself, once per programmed number of level-1 accepts. In external mode it forwards strobes arriving on differential input lines, and in local mode it forwards strobes from an on-chip source. A downscaler then lets through only a fraction of these candidate triggers. Each trigger that is released leaves the block as a one-cycle strobe together with a 12-bit running trigger number.

The block also keeps a saturating 8-bit count of level-1 triggers that no level-2 trigger has yet followed. A busy output is raised while that count is non-zero, so upstream logic can hold back new level-1 triggers. Every trigger input and output is a single-cycle strobe with no back-pressure. A strobe present at a clock edge is taken at that edge and is never held or replayed, and the configuration pins are plain levels that are sampled on every cycle.

Top module: `l2_sched`

## Requirements
- R1: `src_sel` picks the origin of candidate level-2 triggers. 2'b00 is automatic (the pass counter), 2'b01 is `ext_l2`, 2'b10 is `loc_l2`, and 2'b11 yields no candidates. Strobes on an origin that is not selected have no effect.
- R2: In automatic mode a candidate occurs on every N-th `l1_accept`, counted from reset, where N is `pass_cnt`. A value of 0 behaves as 1. The pass counter advances only in automatic mode.
- R3: With `downscale` = D, only every (D+1)-th candidate is released, counted from reset. D = 0 releases every candidate.
- R4: A candidate that is released at clock edge k makes `l2_trig` high for exactly the one cycle that follows edge k.
- R5: `l2_num` counts released triggers modulo 4096. It changes at the same edge at which `l2_trig` rises, and it holds otherwise.
- R6: `diff_cnt` rises by one on each `l1_accept` and falls by one on each released level-2 trigger.
- R7: `diff_cnt` saturates: it stays at 255 on a further increment and stays at 0 on a further decrement. Level-2 triggers are still released while it is at 0.
- R8: An `l1_accept` and a release in the same cycle leave `diff_cnt` unchanged.
- R9: `l2_busy` is high exactly while `diff_cnt` is non-zero.
- R10: After reset, `l2_trig` = 0, `l2_num` = 0, `diff_cnt` = 0, `l2_busy` = 0, and the pass and downscale counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_accept | input | 1 | Strobe: one level-1 trigger accepted |
| ext_l2 | input | 1 | Strobe: level-2 request from the external lines |
| loc_l2 | input | 1 | Strobe: level-2 request from the local source |
| src_sel | input | 2 | Origin select (00 auto, 01 external, 10 local, 11 none) |
| pass_cnt | input | 8 | Number of level-1 accepts per automatic candidate (0 behaves as 1) |
| downscale | input | 8 | Downscale D: every (D+1)-th candidate is released |
| l2_trig | output | 1 | Level-2 trigger strobe, one cycle wide |
| l2_num | output | 12 | Running number of released level-2 triggers |
| diff_cnt | output | 8 | Saturating count of level-1 minus level-2 triggers |
| l2_busy | output | 1 | High while diff_cnt is non-zero |

## Verification
Several properties are checked by assertions on every cycle:
- the difference counter holds on a simultaneous increment and decrement, and it saturates at both ends;
- the trigger number steps by one exactly when the strobe is high;
- a level-1 accept without a release leaves the block busy;
- the pass counter clears after each candidate;
- a zero downscale never drops a candidate;
- the unused source code never yields a strobe.

The arithmetic of the release ratios can only be shown by the bench's scenarios. These are the pass count and downscale sweep in automatic mode, the isolation of the external and local origins, saturation at 255 after a long burst, and the wrap of the trigger number after 4096 releases.

// File: rtl/l2s_pkg.sv
package l2s_pkg;
  typedef enum logic [1:0] {
    SRC_AUTO  = 2'b00,
    SRC_EXT   = 2'b01,
    SRC_LOCAL = 2'b10,
    SRC_NONE  = 2'b11
  } l2_src_e;
endpackage

// File: rtl/l2s_pass_gate.sv
// Counts level-1 accepts and fires a candidate on every N-th one.
module l2s_pass_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         l1,
  input  logic [W-1:0] limit,
  output logic         fire
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt;
  logic [W-1:0] limit_eff;
  logic [W:0]   nxt;
  logic         reach;

  always_comb begin
    limit_eff = (limit == '0) ? ONE : limit;
    nxt       = {1'b0, cnt} + {1'b0, ONE};
    reach     = nxt >= {1'b0, limit_eff};
    fire      = en && l1 && reach;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (en && l1) cnt <= reach ? '0 : cnt + ONE;
  end

  // R2: after a candidate the pass counter starts over
  p_pass_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == '0));
endmodule

// File: rtl/l2s_downscaler.sv
// Releases every (D+1)-th eligible candidate.
module l2s_downscaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         elig,
  input  logic [W-1:0] ratio,
  output logic         emit
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt;

  assign emit = elig && (cnt >= ratio);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (elig) cnt <= emit ? '0 : cnt + ONE;
  end

  // R3: no downscaling when the ratio is zero
  p_ds_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (elig && ratio == '0) |-> emit);
endmodule

// File: rtl/l2s_diff_counter.sv
// Saturating up/down counter of level-1 minus level-2 triggers.
module l2s_diff_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (inc && !dec && cnt != TOP) cnt <= cnt + ONE;
    else if (dec && !inc && cnt != '0) cnt <= cnt - ONE;
  end

  // R8: simultaneous increment and decrement hold the value
  p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt));
  // R7: saturation at the top
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && inc) |=> (cnt == TOP));
  // R7: saturation at zero
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && dec) |=> (cnt == '0));
endmodule

// File: rtl/l2_sched.sv
module l2_sched #(
  parameter int CNT_W  = 8,
  parameter int NUM_W  = 12,
  parameter int DIFF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l1_accept,
  input  logic              ext_l2,
  input  logic              loc_l2,
  input  logic [1:0]        src_sel,
  input  logic [CNT_W-1:0]  pass_cnt,
  input  logic [CNT_W-1:0]  downscale,
  output logic              l2_trig,
  output logic [NUM_W-1:0]  l2_num,
  output logic [DIFF_W-1:0] diff_cnt,
  output logic              l2_busy
);
  import l2s_pkg::*;

  localparam logic [NUM_W-1:0] NUM_ONE = {{(NUM_W-1){1'b0}}, 1'b1};

  l2_src_e src;
  logic    auto_en;
  logic    auto_fire;
  logic    elig;
  logic    emit;

  assign src     = l2_src_e'(src_sel);
  assign auto_en = (src == SRC_AUTO);

  l2s_pass_gate #(.W(CNT_W)) u_pass (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (auto_en),
    .l1    (l1_accept),
    .limit (pass_cnt),
    .fire  (auto_fire)
  );

  always_comb begin
    unique case (src)
      SRC_AUTO:  elig = auto_fire;
      SRC_EXT:   elig = ext_l2;
      SRC_LOCAL: elig = loc_l2;
      default:   elig = 1'b0;
    endcase
  end

  l2s_downscaler #(.W(CNT_W)) u_ds (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig),
    .ratio (downscale),
    .emit  (emit)
  );

  l2s_diff_counter #(.W(DIFF_W)) u_diff (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (l1_accept),
    .dec   (emit),
    .cnt   (diff_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l2_trig <= 1'b0;
      l2_num  <= '0;
    end else begin
      l2_trig <= emit;
      if (emit) l2_num <= l2_num + NUM_ONE;
    end
  end

  assign l2_busy = (diff_cnt != '0);

  // R5: the number steps with each strobe
  p_num_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    l2_trig |-> (l2_num == $past(l2_num) + NUM_ONE));
  // R5: the number holds between strobes
  p_num_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !l2_trig |-> $stable(l2_num));
  // R1: the unused source code never yields a trigger
  p_none_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b11) |=> !l2_trig);
  // R9: an unmatched level-1 accept leaves the block busy
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_accept && !emit) |=> l2_busy);
endmodule

// File: tb/l2_sched_test.sv
`timescale 1ns/1ps
module l2_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l1_accept = 1'b0;
  logic        ext_l2 = 1'b0;
  logic        loc_l2 = 1'b0;
  logic [1:0]  src_sel = 2'b00;
  logic [7:0]  pass_cnt = 8'd1;
  logic [7:0]  downscale = 8'd0;
  logic        l2_trig;
  logic [11:0] l2_num;
  logic [7:0]  diff_cnt;
  logic        l2_busy;

  int checks = 0;
  int fails = 0;
  int seen = 0;

  always #2 clk = ~clk;

  l2_sched uut (
    .clk(clk), .rst_n(rst_n), .l1_accept(l1_accept), .ext_l2(ext_l2),
    .loc_l2(loc_l2), .src_sel(src_sel), .pass_cnt(pass_cnt),
    .downscale(downscale), .l2_trig(l2_trig), .l2_num(l2_num),
    .diff_cnt(diff_cnt), .l2_busy(l2_busy)
  );

  always @(negedge clk) if (rst_n && l2_trig) seen++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    l1_accept = 1'b0; ext_l2 = 1'b0; loc_l2 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    seen = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int auto_exp(input int m, input int n, input int d);
    int nn;
    nn = (n == 0) ? 1 : n;
    return (m / nn) / (d + 1);
  endfunction

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R10: reset state
    do_reset();
    idle(1);
    chk("R10 l2_trig", l2_trig, 0);
    chk("R10 l2_num", l2_num, 0);
    chk("R10 diff_cnt", diff_cnt, 0);
    chk("R10 l2_busy", l2_busy, 0);

    // R4, R8: strobe timing, simultaneous inc/dec
    src_sel = 2'b00; pass_cnt = 8'd1; downscale = 8'd0;
    do_reset();
    l1_accept = 1'b1;
    chk("R4 no strobe before edge", l2_trig, 0);
    @(negedge clk);
    l1_accept = 1'b0;
    chk("R4 strobe after edge", l2_trig, 1);
    chk("R8 diff unchanged", diff_cnt, 0);
    chk("R5 number one", l2_num, 1);
    @(negedge clk);
    chk("R4 strobe one cycle", l2_trig, 0);

    // R2, R3, R6: sweep pass count and downscale in auto mode
    for (int n = 0; n <= 4; n++) begin
      for (int d = 0; d <= 3; d++) begin
        src_sel = 2'b00; pass_cnt = 8'(n); downscale = 8'(d);
        do_reset();
        for (int i = 0; i < 24; i++) begin
          l1_accept = 1'b1; @(negedge clk);
          l1_accept = 1'b0; @(negedge clk);
        end
        idle(2);
        chk($sformatf("R2/R3 count n=%0d d=%0d", n, d), seen, auto_exp(24, n, d));
        chk($sformatf("R5 number n=%0d d=%0d", n, d), l2_num, auto_exp(24, n, d));
        chk($sformatf("R6 diff n=%0d d=%0d", n, d), diff_cnt, 24 - auto_exp(24, n, d));
      end
    end

    // R1: external origin, local strobes ignored, D=2
    src_sel = 2'b01; downscale = 8'd2;
    do_reset();
    for (int i = 0; i < 9; i++) begin
      ext_l2 = 1'b1; @(negedge clk); ext_l2 = 1'b0;
      loc_l2 = 1'b1; @(negedge clk); loc_l2 = 1'b0;
      l1_accept = 1'b1; @(negedge clk); l1_accept = 1'b0;
    end
    idle(2);
    chk("R1 external count", seen, 3);
    chk("R1 external number", l2_num, 3);

    // R1: local origin, external strobes ignored, D=0
    src_sel = 2'b10; downscale = 8'd0;
    do_reset();
    for (int i = 0; i < 9; i++) begin
      loc_l2 = 1'b1; @(negedge clk); loc_l2 = 1'b0;
      ext_l2 = 1'b1; @(negedge clk); ext_l2 = 1'b0;
    end
    idle(2);
    chk("R1 local count", seen, 9);

    // R1, R7, R9: no origin, long burst saturates at 255
    src_sel = 2'b11;
    do_reset();
    l1_accept = 1'b1; ext_l2 = 1'b1; loc_l2 = 1'b1;
    repeat (300) @(negedge clk);
    l1_accept = 1'b0; ext_l2 = 1'b0; loc_l2 = 1'b0;
    idle(2);
    chk("R1 none count", seen, 0);
    chk("R7 diff top", diff_cnt, 255);
    chk("R9 busy high", l2_busy, 1);

    // R6, R7, R9: drain to zero via external strobes, then beyond
    src_sel = 2'b01; downscale = 8'd0;
    ext_l2 = 1'b1;
    repeat (255) @(negedge clk);
    ext_l2 = 1'b0;
    idle(1);
    chk("R6 drained", diff_cnt, 0);
    chk("R9 busy low", l2_busy, 0);
    ext_l2 = 1'b1;
    repeat (5) @(negedge clk);
    ext_l2 = 1'b0;
    idle(2);
    chk("R7 diff bottom", diff_cnt, 0);
    chk("R7 release at zero", l2_num, 260);

    // R2: pass counter frozen outside auto mode
    pass_cnt = 8'd3; downscale = 8'd0;
    do_reset();
    src_sel = 2'b00;
    l1_accept = 1'b1; @(negedge clk);
    l1_accept = 1'b1; @(negedge clk); l1_accept = 1'b0;
    src_sel = 2'b01;
    l1_accept = 1'b1; repeat (4) @(negedge clk); l1_accept = 1'b0;
    src_sel = 2'b00;
    l1_accept = 1'b1; @(negedge clk); l1_accept = 1'b0;
    idle(2);
    chk("R2 frozen outside auto", seen, 1);

    // R5: number wraps after 4096 releases
    src_sel = 2'b01; downscale = 8'd0;
    do_reset();
    ext_l2 = 1'b1;
    repeat (4096) @(negedge clk);
    ext_l2 = 1'b0;
    idle(2);
    chk("R5 wrap count", seen, 4096);
    chk("R5 wrap number", l2_num, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule